// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates virtual addresses into physical addresses through a small fully associative table of page mappings. Every entry holds its own page-size mask, so one table can hold 4 KB pages next to 16 KB, 64 KB and up to 16 MB pages. A translation request is answered in the same cycle it is presented. The response is either a physical address or one of three fault codes: no mapping, a mapping marked not present, or a store to a page marked read-only.

Entries are loaded through a write port. The write port either names a slot directly or hands the choice to a replacement pointer. A programmable count reserves the lowest slots, and the replacement pointer never selects them. This keeps critical mappings resident. A probe port searches the table for an address and reports which slot holds it.

Top module: `tlb_xlate`

## Requirements
- R1: After reset the replacement pointer is ENTRIES-1 and the reserved count is 0. Every slot is cleared to page 0, tag 0, not shared, not present and read-only, so a lookup carrying a nonzero tag gets code 1.
- R2: A lookup that matches a present slot sets `lk_hit` in the same cycle. It returns `{frame, vaddr[11:0]}` for a 4 KB page (mask 0), with fault code 0.
- R3: Mask bit k makes the compare ignore virtual address bit 12+k and passes that bit through into the physical address in place of frame bit k. Masks 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF give pages of 4 KB to 16 MB.
- R4: A slot matches only when its address tag equals `lk_asid`, unless its shared bit is set.
- R5: A lookup that matches no slot returns fault code 1 (refill).
- R6: A lookup that matches a slot whose present bit is clear returns fault code 2 (invalid), for loads and for stores.
- R7: A store that matches a present slot whose writable bit is clear returns fault code 3 (modified). A load to the same slot translates normally.
- R8: With `lk_req` low, `lk_hit` is 0 and the fault code is 0.
- R9: A direct write (`wr_random` = 0) updates the slot named by `wr_index`, reserved slots included.
- R10: A replacement write (`wr_random` = 1) updates the slot named by `rnd_index`. The pointer then counts down by one, or returns to ENTRIES-1 when it stood at the reserved count. With no replacement write it holds.
- R11: Writing the reserved count with `lock_we` moves the pointer to ENTRIES-1. The pointer never drops below the count, so a replacement write never changes a slot below it.
- R12: The probe port reports `pr_found` and the lowest matching slot index for `pr_vaddr`/`pr_asid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address tag |
| lk_store | input | 1 | Lookup is a store |
| lk_paddr | output | PA_W | Physical address (0 unless hit) |
| lk_hit | output | 1 | Translation succeeded |
| lk_exc | output | 2 | Fault code: 0 none, 1 refill, 2 invalid, 3 modified |
| wr_en | input | 1 | Write a slot |
| wr_random | input | 1 | Use replacement pointer instead of wr_index |
| wr_index | input | IDX_W | Slot for a direct write |
| wr_vpn | input | VA_W-12 | Virtual page number |
| wr_mask | input | MASK_W | Page-size mask |
| wr_asid | input | ASID_W | Address tag |
| wr_global | input | 1 | Shared: ignore address tag |
| wr_pfn | input | PA_W-12 | Physical frame number |
| wr_valid | input | 1 | Present bit |
| wr_dirty | input | 1 | Writable bit |
| lock_we | input | 1 | Load reserved count |
| lock_val | input | IDX_W | New reserved count |
| rnd_index | output | IDX_W | Current replacement pointer |
| pr_vaddr | input | VA_W | Probe virtual address |
| pr_asid | input | ASID_W | Probe address tag |
| pr_found | output | 1 | Probe matched a slot |
| pr_index | output | IDX_W | Lowest matching slot |

## Verification
The bench builds the block with its defaults: 32 slots, 32-bit addresses, 8-bit tags and a 12-bit mask. This brings the full range from 4 KB to 16 MB pages within reach. A reserved count of 30 makes the pointer wrap after two replacement writes. A reserved count of 2 lets a full sweep of 31 replacement writes cover every unreserved slot and wrap once, while the two reserved mappings must survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        EXC_NONE     = 2'd0,
        EXC_REFILL   = 2'd1,
        EXC_INVALID  = 2'd2,
        EXC_MODIFIED = 2'd3
    } tlb_exc_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int MASK_W  = 12,
    parameter int ASID_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [VPN_W-1:0]                  wr_vpn,
    input  logic [MASK_W-1:0]                 wr_mask,
    input  logic [ASID_W-1:0]                 wr_asid,
    input  logic                              wr_global,
    input  logic [PFN_W-1:0]                  wr_pfn,
    input  logic                              wr_valid,
    input  logic                              wr_dirty,
    output logic [ENTRIES-1:0][VPN_W-1:0]     e_vpn,
    output logic [ENTRIES-1:0][MASK_W-1:0]    e_mask,
    output logic [ENTRIES-1:0][ASID_W-1:0]    e_asid,
    output logic [ENTRIES-1:0]                e_glob,
    output logic [ENTRIES-1:0][PFN_W-1:0]     e_pfn,
    output logic [ENTRIES-1:0]                e_valid,
    output logic [ENTRIES-1:0]                e_dirty
);
    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
    } slot_t;

    slot_t [ENTRIES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = '{vpn: wr_vpn, mask: wr_mask, asid: wr_asid,
                              glob: wr_global, pfn: wr_pfn,
                              valid: wr_valid, dirty: wr_dirty};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
        assign e_vpn[g]   = tab_q[g].vpn;
        assign e_mask[g]  = tab_q[g].mask;
        assign e_asid[g]  = tab_q[g].asid;
        assign e_glob[g]  = tab_q[g].glob;
        assign e_pfn[g]   = tab_q[g].pfn;
        assign e_valid[g] = tab_q[g].valid;
        assign e_dirty[g] = tab_q[g].dirty;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int MASK_W  = 12,
    parameter int ASID_W  = 8
) (
    input  logic [VPN_W-1:0]                  q_vpn,
    input  logic [ASID_W-1:0]                 q_asid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     e_vpn,
    input  logic [ENTRIES-1:0][MASK_W-1:0]    e_mask,
    input  logic [ENTRIES-1:0][ASID_W-1:0]    e_asid,
    input  logic [ENTRIES-1:0]                e_glob,
    output logic [ENTRIES-1:0]                hits
);
    localparam int PAD_W = VPN_W - MASK_W;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] care;
        logic             page_eq;
        logic             tag_eq;
        assign care    = ~{{PAD_W{1'b0}}, e_mask[g]};
        assign page_eq = ((q_vpn ^ e_vpn[g]) & care) == '0;
        assign tag_eq  = e_glob[g] || (e_asid[g] == q_asid);
        assign hits[g] = page_eq && tag_eq;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_val,
    input  logic             rand_wr,
    output logic [IDX_W-1:0] rnd_idx,
    output logic [IDX_W-1:0] lock_cnt
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] rnd;
        logic [IDX_W-1:0] lock;
    } vic_t;

    vic_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_we) begin
            st_d.lock = (lock_val > TOP) ? TOP : lock_val;
            st_d.rnd  = TOP;
        end else if (rand_wr) begin
            st_d.rnd = (st_q.rnd <= st_q.lock) ? TOP : st_q.rnd - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rnd: TOP, lock: '0};
        else        st_q <= st_d;
    end

    assign rnd_idx  = st_q.rnd;
    assign lock_cnt = st_q.lock;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int ENTRIES    = 32,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int MASK_W     = 12,
    parameter int ASID_W     = 8,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_hit,
    output logic [1:0]        lk_exc,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              lock_we,
    input  logic [IDX_W-1:0]  lock_val,
    output logic [IDX_W-1:0]  rnd_index,
    input  logic [VA_W-1:0]   pr_vaddr,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              pr_found,
    output logic [IDX_W-1:0]  pr_index
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][MASK_W-1:0] e_mask;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0]             e_glob;
    logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0]             e_dirty;
    logic [ENTRIES-1:0]             lk_hits, pr_hits;
    logic [IDX_W-1:0]               lock_cnt;
    logic [IDX_W-1:0]               slot_idx;

    assign slot_idx = wr_random ? rnd_index : wr_index;

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_val(lock_val),
        .rand_wr(wr_en && wr_random), .rnd_idx(rnd_index), .lock_cnt(lock_cnt)
    );

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W),
                .MASK_W(MASK_W), .ASID_W(ASID_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(slot_idx),
        .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_valid(wr_valid),
        .wr_dirty(wr_dirty), .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid),
        .e_glob(e_glob), .e_pfn(e_pfn), .e_valid(e_valid), .e_dirty(e_dirty)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .MASK_W(MASK_W), .ASID_W(ASID_W)) u_lk_cam (
        .q_vpn(lk_vaddr[VA_W-1:PAGE_SHIFT]), .q_asid(lk_asid),
        .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
        .hits(lk_hits)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .MASK_W(MASK_W), .ASID_W(ASID_W)) u_pr_cam (
        .q_vpn(pr_vaddr[VA_W-1:PAGE_SHIFT]), .q_asid(pr_asid),
        .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
        .hits(pr_hits)
    );

    // Lookup path: one-hot select of the matching slot, then fault decode.
    logic [PFN_W-1:0]  sel_pfn;
    logic [MASK_W-1:0] sel_mask;
    logic              sel_valid, sel_dirty, found;
    logic [PFN_W-1:0]  frame;
    tlb_exc_e          exc;

    always_comb begin
        sel_pfn   = '0;
        sel_mask  = '0;
        sel_valid = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hits[i]) begin
                sel_pfn   = sel_pfn   | e_pfn[i];
                sel_mask  = sel_mask  | e_mask[i];
                sel_valid = sel_valid | e_valid[i];
                sel_dirty = sel_dirty | e_dirty[i];
            end
        end
        found = |lk_hits;
    end

    always_comb begin
        frame = sel_pfn;
        frame[MASK_W-1:0] = (sel_pfn[MASK_W-1:0] & ~sel_mask)
                          | (lk_vaddr[PAGE_SHIFT +: MASK_W] & sel_mask);
    end

    always_comb begin
        if (!lk_req)                     exc = EXC_NONE;
        else if (!found)                 exc = EXC_REFILL;
        else if (!sel_valid)             exc = EXC_INVALID;
        else if (lk_store && !sel_dirty) exc = EXC_MODIFIED;
        else                             exc = EXC_NONE;
    end

    assign lk_hit   = lk_req && (exc == EXC_NONE);
    assign lk_exc   = exc;
    assign lk_paddr = lk_hit ? {frame, lk_vaddr[PAGE_SHIFT-1:0]} : '0;

    // Probe path: lowest matching slot wins.
    always_comb begin
        pr_index = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (pr_hits[i]) pr_index = IDX_W'(i);
        end
    end
    assign pr_found = |pr_hits;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int ENTRIES    = 32,
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ASID_W     = 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [1:0]        lk_exc,
    input logic [VA_W-1:0]   pr_vaddr,
    input logic [ASID_W-1:0] pr_asid,
    input logic              pr_found,
    input logic              wr_en,
    input logic              wr_random,
    input logic              lock_we,
    input logic [IDX_W-1:0]  rnd_index,
    input logic [IDX_W-1:0]  lock_cnt
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    a_r11_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_index >= lock_cnt && rnd_index <= TOP);

    a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_random && !lock_we) |=>
        (rnd_index == (($past(rnd_index) == $past(lock_cnt)) ? TOP : IDX_W'($past(rnd_index) - 1'b1))));

    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_random) && !lock_we) |=> $stable(rnd_index));

    a_r11_lock_restart: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> rnd_index == TOP);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && lk_exc == 2'd0));

    a_r2_hit_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_exc == 2'd0 && lk_req));

    a_r5_refill_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_exc == 2'd1 && lk_asid == pr_asid &&
         lk_vaddr[VA_W-1:PAGE_SHIFT] == pr_vaddr[VA_W-1:PAGE_SHIFT]) |-> !pr_found);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_exc(lk_exc),
    .pr_vaddr(pr_vaddr), .pr_asid(pr_asid), .pr_found(pr_found),
    .wr_en(wr_en), .wr_random(wr_random), .lock_we(lock_we),
    .rnd_index(rnd_index), .lock_cnt(lock_cnt)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic [31:0] lk_paddr;
    logic        lk_hit;
    logic [1:0]  lk_exc;
    logic        wr_en = 1'b0, wr_random = 1'b0;
    logic [4:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0;
    logic [11:0] wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic        wr_valid = 1'b0, wr_dirty = 1'b0;
    logic        lock_we = 1'b0;
    logic [4:0]  lock_val = '0;
    logic [4:0]  rnd_index;
    logic [31:0] pr_vaddr = '0;
    logic [7:0]  pr_asid = '0;
    logic        pr_found;
    logic [4:0]  pr_index;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_store(lk_store), .lk_paddr(lk_paddr),
        .lk_hit(lk_hit), .lk_exc(lk_exc), .wr_en(wr_en), .wr_random(wr_random),
        .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
        .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn(wr_pfn),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty), .lock_we(lock_we),
        .lock_val(lock_val), .rnd_index(rnd_index), .pr_vaddr(pr_vaddr),
        .pr_asid(pr_asid), .pr_found(pr_found), .pr_index(pr_index)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic rnd, input logic [4:0] idx, input logic [19:0] vpn,
                       input logic [11:0] mask, input logic [7:0] asid, input logic g,
                       input logic [19:0] pfn, input logic v, input logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_mask = mask;
        wr_asid = asid; wr_global = g; wr_pfn = pfn; wr_valid = v; wr_dirty = d;
        @(negedge clk);
        wr_en = 1'b0; wr_random = 1'b0;
    endtask

    task automatic set_lock(input logic [4:0] n);
        @(negedge clk);
        lock_we = 1'b1; lock_val = n;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st,
                        input logic [1:0] ex, input logic [31:0] pa, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
        #1;
        check(lk_exc == ex, {tag, " code"}, 32'(lk_exc), 32'(ex));
        check(lk_hit == (ex == 2'd0), {tag, " hit"}, 32'(lk_hit), 32'(ex == 2'd0));
        if (ex == 2'd0) check(lk_paddr == pa, {tag, " paddr"}, lk_paddr, pa);
    endtask

    task automatic probe(input logic [31:0] va, input logic [7:0] asid,
                         input logic f, input logic [4:0] idx, input string tag);
        @(negedge clk);
        pr_vaddr = va; pr_asid = asid;
        #1;
        check(pr_found == f, {tag, " found"}, 32'(pr_found), 32'(f));
        if (f) check(pr_index == idx, {tag, " index"}, 32'(pr_index), 32'(idx));
    endtask

    task automatic t_reset;
        check(rnd_index == 5'd31, "R1 pointer at reset", 32'(rnd_index), 32'd31);
        look(32'h1234_5000, 8'd1, 1'b0, 2'd1, 32'h0, "R1 cleared table");
    endtask

    task automatic t_basic;
        put(1'b0, 5'd0, 20'h00400, 12'h000, 8'd3, 1'b0, 20'h12345, 1'b1, 1'b1);
        look(32'h0040_0ABC, 8'd3, 1'b0, 2'd0, 32'h1234_5ABC, "R2 4KB load");
        look(32'h0040_0FFF, 8'd3, 1'b1, 2'd0, 32'h1234_5FFF, "R2 4KB store");
        look(32'h0040_1000, 8'd3, 1'b0, 2'd1, 32'h0, "R5 next page misses");
    endtask

    task automatic t_tag;
        look(32'h0040_0ABC, 8'd4, 1'b0, 2'd1, 32'h0, "R4 wrong tag");
        put(1'b0, 5'd1, 20'h00500, 12'h000, 8'd9, 1'b1, 20'h33333, 1'b1, 1'b1);
        look(32'h0050_0010, 8'd77, 1'b0, 2'd0, 32'h3333_3010, "R4 shared slot");
    endtask

    task automatic t_sizes;
        put(1'b0, 5'd2, 20'h00800, 12'h003, 8'd3, 1'b0, 20'h20000, 1'b1, 1'b1);
        look(32'h0080_3123, 8'd3, 1'b0, 2'd0, 32'h2000_3123, "R3 16KB inside");
        look(32'h0080_4123, 8'd3, 1'b0, 2'd1, 32'h0, "R3 16KB outside");
        put(1'b0, 5'd3, 20'h01000, 12'hFFF, 8'd3, 1'b0, 20'h80000, 1'b1, 1'b1);
        look(32'h01AB_CDEF, 8'd3, 1'b0, 2'd0, 32'h80AB_CDEF, "R3 16MB inside");
        look(32'h0200_0000, 8'd3, 1'b0, 2'd1, 32'h0, "R3 16MB outside");
    endtask

    task automatic t_faults;
        put(1'b0, 5'd4, 20'h00900, 12'h000, 8'd3, 1'b0, 20'h11111, 1'b0, 1'b1);
        look(32'h0090_0004, 8'd3, 1'b0, 2'd2, 32'h0, "R6 not present load");
        look(32'h0090_0004, 8'd3, 1'b1, 2'd2, 32'h0, "R6 not present store");
        put(1'b0, 5'd5, 20'h00A00, 12'h000, 8'd3, 1'b0, 20'h44444, 1'b1, 1'b0);
        look(32'h00A0_0008, 8'd3, 1'b1, 2'd3, 32'h0, "R7 store read-only");
        look(32'h00A0_0008, 8'd3, 1'b0, 2'd0, 32'h4444_4008, "R7 load read-only");
    endtask

    task automatic t_idle;
        @(negedge clk);
        lk_req = 1'b0; lk_vaddr = 32'h0040_0ABC; lk_asid = 8'd3; lk_store = 1'b0;
        #1;
        check(!lk_hit, "R8 idle hit", 32'(lk_hit), 32'd0);
        check(lk_exc == 2'd0, "R8 idle code", 32'(lk_exc), 32'd0);
        @(negedge clk);
        lk_vaddr = 32'h7777_7000;
        #1;
        check(lk_exc == 2'd0, "R8 idle unmapped", 32'(lk_exc), 32'd0);
    endtask

    task automatic t_probe;
        probe(32'h00A0_0010, 8'd3, 1'b1, 5'd5, "R12 probe slot 5");
        probe(32'h01FF_F000, 8'd3, 1'b1, 5'd3, "R12 probe big page");
        probe(32'h0FFF_F000, 8'd3, 1'b0, 5'd0, "R12 probe miss");
    endtask

    task automatic t_replace;
        set_lock(5'd4);
        check(rnd_index == 5'd31, "R11 lock restart", 32'(rnd_index), 32'd31);
        put(1'b1, 5'd0, 20'h00B00, 12'h000, 8'd3, 1'b0, 20'h55555, 1'b1, 1'b1);
        look(32'h00B0_0020, 8'd3, 1'b0, 2'd0, 32'h5555_5020, "R10 replaced slot");
        probe(32'h00B0_0000, 8'd3, 1'b1, 5'd31, "R10 slot 31 written");
        check(rnd_index == 5'd30, "R10 pointer step", 32'(rnd_index), 32'd30);
        look(32'h0040_0ABC, 8'd3, 1'b0, 2'd0, 32'h1234_5ABC, "R10 wr_index ignored");
    endtask

    task automatic t_wrap;
        set_lock(5'd30);
        check(rnd_index == 5'd31, "R11 lock restart 30", 32'(rnd_index), 32'd31);
        put(1'b1, 5'd0, 20'h00C00, 12'h000, 8'd3, 1'b0, 20'h66666, 1'b1, 1'b1);
        check(rnd_index == 5'd30, "R10 pointer at lock", 32'(rnd_index), 32'd30);
        put(1'b1, 5'd0, 20'h00D00, 12'h000, 8'd3, 1'b0, 20'h77777, 1'b1, 1'b1);
        check(rnd_index == 5'd31, "R10 pointer wraps", 32'(rnd_index), 32'd31);
        probe(32'h00D0_0000, 8'd3, 1'b1, 5'd30, "R10 slot 30 written");
        look(32'h00B0_0020, 8'd3, 1'b0, 2'd1, 32'h0, "R10 slot 31 replaced");
        repeat (3) @(negedge clk);
        check(rnd_index == 5'd31, "R10 pointer holds", 32'(rnd_index), 32'd31);
    endtask

    task automatic t_direct_locked;
        put(1'b0, 5'd0, 20'h00E00, 12'h000, 8'd3, 1'b0, 20'h0ABCD, 1'b1, 1'b1);
        look(32'h00E0_0111, 8'd3, 1'b0, 2'd0, 32'h0ABC_D111, "R9 direct into reserved");
        look(32'h0040_0ABC, 8'd3, 1'b0, 2'd1, 32'h0, "R9 old slot 0 gone");
        check(rnd_index == 5'd31, "R9 pointer untouched", 32'(rnd_index), 32'd31);
    endtask

    task automatic t_sweep;
        put(1'b0, 5'd0, 20'h60000, 12'h000, 8'd0, 1'b1, 20'h0AAAA, 1'b1, 1'b1);
        put(1'b0, 5'd1, 20'h60001, 12'h000, 8'd0, 1'b1, 20'h0BBBB, 1'b1, 1'b1);
        set_lock(5'd2);
        for (int i = 0; i < 31; i++) begin
            put(1'b1, 5'd0, 20'h70000 + 20'(i), 12'h000, 8'd0, 1'b1, 20'h00100 + 20'(i), 1'b1, 1'b1);
            if (i == 29) check(rnd_index == 5'd31, "R11 sweep wraps", 32'(rnd_index), 32'd31);
        end
        check(rnd_index == 5'd30, "R11 after sweep", 32'(rnd_index), 32'd30);
        look(32'h6000_0123, 8'd5, 1'b0, 2'd0, 32'h0AAA_A123, "R11 reserved slot 0 kept");
        look(32'h6000_1123, 8'd5, 1'b0, 2'd0, 32'h0BBB_B123, "R11 reserved slot 1 kept");
        probe(32'h7001_D000, 8'd0, 1'b1, 5'd2, "R11 lowest free slot");
        probe(32'h7001_E000, 8'd0, 1'b1, 5'd31, "R11 second pass slot");
        look(32'h7000_0000, 8'd0, 1'b0, 2'd1, 32'h0, "R11 first pass overwritten");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_tag();
        t_sizes();
        t_faults();
        t_idle();
        t_probe();
        t_replace();
        t_wrap();
        t_direct_locked();
        t_sweep();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule